// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block merges five raw interrupt sources into one general interrupt output and one wake-up request. Each source has its own programmable active level, its own choice between pass-through and latched (sticky) reporting, and its own wake-up enable. Software reaches four 16-bit registers through a synchronous port made of an address, a write strobe, write data and combinational read data.

The raw sources first cross a two-stage synchronizer. Each synchronized level is compared with its polarity bit, and the result is the source's internal asserted signal. A pass-through source shows that signal directly in the status register. A sticky source keeps a latch that sets whenever the signal is asserted. The latch holds until software writes a zero to that status bit. The interrupt output is the OR of the status bits, gated by an active-low disable bit. That bit resets to one, so the output is off after reset. The wake-up request is the OR of the status bits that have their wake-up enable set.

The source order in the status word is fixed. Bit 15 is comparator 1, bit 14 is comparator 2, bit 13 is pen-down, bit 12 is auxiliary ADC data ready, and bit 11 is the thermal sensor. On the `src_raw` port, `src_raw[4]` maps to bit 15 and `src_raw[0]` maps to bit 11.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the registers read as follows: address 0 (level) reads 16'hF801, address 1 (latch mode) reads 16'h0000, address 2 (wake enable) reads 16'h0000. irq_out and wake_req are 0.
- R2: Registers 0 to 2 keep only bits 15:11 as per-source fields. Register 0 also keeps bit 0 as the output-disable bit. Every other bit reads as 0 and ignores writes. Status (address 3) bits 10:0 always read 0.
- R3: A source is asserted when its synchronized raw level equals its level bit: raw XNOR level bit.
- R4: A change on src_raw is not yet visible in status after one rising edge. It is visible after the second rising edge.
- R5: With its latch-mode bit at 0, a source's status bit follows its asserted signal in both directions.
- R6: With its latch-mode bit at 1, a source's status bit becomes 1 when the source asserts. It stays 1 after the source deasserts.
- R7: Writing 0 to a status bit of a latched source clears it. Writing 1 has no effect. Reading status never clears a bit.
- R8: If the source is asserted in the same cycle as a clearing write, the latch stays set.
- R9: irq_out is 1 exactly when register 0 bit 0 is 0 and at least one status bit is 1.
- R10: wake_req is 1 exactly when some status bit is 1 and its wake-enable bit (address 2, same position) is 1.

Register addresses: 0 is the level register, 1 is the latch mode register, 2 is the wake enable register, and 3 is status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_raw | input | 5 | Raw interrupt sources; bit 4 maps to status bit 15 |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq_out | output | 1 | General interrupt output |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench sweeps all 32 raw patterns under four level settings, so a flipped XNOR or a swapped bit order shows up as wrong status, interrupt or wake values. It times the synchronizer edge by edge, which catches a missing or extra stage. It drives a single-cycle assertion that lands exactly on a clearing write. A design that gives the clear priority would lose that event. The bench also writes ones and reads status repeatedly; a design that clears on write-one or on read would drop a held latch. Finally, it checks that the output stays low while the disable bit is at its reset value, which catches an ungated interrupt after reset.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NSRC    = 5;
    localparam int DW      = 16;
    localparam int AW      = 2;
    localparam int SRC_LSB = DW - NSRC;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [AW-1:0] {
        ADDR_LEVEL = 2'd0,
        ADDR_MODE  = 2'd1,
        ADDR_WAKE  = 2'd2,
        ADDR_STAT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [N-1:0]  status,
    output logic [N-1:0]  level,
    output logic [N-1:0]  mode,
    output logic [N-1:0]  wake_en,
    output logic          out_dis,
    output logic [N-1:0]  clr,
    output logic [W-1:0]  rdata
);
    localparam int LSB = W - N;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= '1;
            mode    <= '0;
            wake_en <= '0;
            out_dis <= 1'b1;
        end else if (we) begin
            unique case (sel)
                ADDR_LEVEL: begin
                    level   <= wdata[W-1:LSB];
                    out_dis <= wdata[0];
                end
                ADDR_MODE:  mode    <= wdata[W-1:LSB];
                ADDR_WAKE:  wake_en <= wdata[W-1:LSB];
                ADDR_STAT:  ;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (we && sel == ADDR_STAT) clr = ~wdata[W-1:LSB];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADDR_LEVEL: begin
                rdata[W-1:LSB] = level;
                rdata[0]       = out_dis;
            end
            ADDR_MODE: rdata[W-1:LSB] = mode;
            ADDR_WAKE: rdata[W-1:LSB] = wake_en;
            ADDR_STAT: rdata[W-1:LSB] = status;
        endcase
    end
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] act,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic held;
        always_ff @(posedge clk) begin
            if (!rst_n) held <= 1'b0;
            else        held <= mode[i] & (act[i] | (held & ~clr[i]));
        end
        assign status[i] = mode[i] ? (held | act[i]) : act[i];
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_raw,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          irq_out,
    output logic          wake_req
);
    logic [N-1:0] src_s, act, level, mode, wake_en, clr, status;
    logic         out_dis;

    irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_s)
    );

    assign act = ~(src_s ^ level);

    irq_latch #(.N(N)) u_latch (
        .clk(clk), .rst_n(rst_n), .act(act), .mode(mode),
        .clr(clr), .status(status)
    );

    irq_regs #(.N(N), .W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .status(status), .level(level), .mode(mode),
        .wake_en(wake_en), .out_dis(out_dis), .clr(clr), .rdata(reg_rdata)
    );

    assign irq_out  = ~out_dis & (|status);
    assign wake_req = |(status & wake_en);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [W-1:0]  reg_rdata,
    input logic [N-1:0]  status,
    input logic [N-1:0]  mode,
    input logic [N-1:0]  wake_en,
    input logic          out_dis,
    input logic          irq_out,
    input logic          wake_req
);
    localparam int LSB = W - N;

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> !irq_out);

    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_out);

    assert_wake_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en == '0) |-> !wake_req);

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((status & $past(status & mode)) == $past(status & mode)));

    assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STAT) |-> (reg_rdata[LSB-1:0] == '0));
endmodule

bind irq_aggregator irq_agg_chk #(.N(N), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .status(status), .mode(mode), .wake_en(wake_en),
    .out_dis(out_dis), .irq_out(irq_out), .wake_req(wake_req)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_raw = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out, wake_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [4:0]  lv [4];
        lv[0] = 5'h1F; lv[1] = 5'h00; lv[2] = 5'h15; lv[3] = 5'h0A;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset values
        rd(2'd0, v); chk("R1 level reset", v, 16'hF801);
        rd(2'd1, v); chk("R1 mode reset", v, 16'h0000);
        rd(2'd2, v); chk("R1 wake reset", v, 16'h0000);
        chk("R1 irq reset", {15'b0, irq_out}, 16'h0);
        chk("R1 wake_req reset", {15'b0, wake_req}, 16'h0);

        // R2 unused bits ignored
        wr(2'd1, 16'h07FF); rd(2'd1, v); chk("R2 mode unused bits", v, 16'h0000);
        wr(2'd2, 16'h07FF); rd(2'd2, v); chk("R2 wake unused bits", v, 16'h0000);
        wr(2'd0, 16'hFFFE); rd(2'd0, v); chk("R2 level unused bits", v, 16'hF800);

        // R9 output disabled: source asserted, disable bit set
        wr(2'd0, 16'hF801);
        src_raw = 5'h10; tick(2);
        rd(2'd3, v); chk("R9 status under disable", v, 16'h8000);
        chk("R9 irq gated", {15'b0, irq_out}, 16'h0);
        src_raw = 5'h00; tick(2);

        // R4 synchronizer latency
        wr(2'd0, 16'hF800);
        src_raw = 5'h01; reg_addr = 2'd3;
        tick(1); rd(2'd3, v); chk("R4 one edge not visible", v, 16'h0000);
        tick(1); rd(2'd3, v); chk("R4 two edges visible", v, 16'h0800);
        src_raw = 5'h00; tick(2);

        // R3 R5 R9 R10 sweep, wake enable fixed at 10110
        wr(2'd2, 16'hB000);
        for (int p = 0; p < 4; p++) begin
            wr(2'd0, {lv[p], 11'b0});
            for (int r = 0; r < 32; r++) begin
                logic [4:0] st;
                st = ~(r[4:0] ^ lv[p]);
                src_raw = r[4:0];
                tick(2);
                rd(2'd3, v);
                chk("R3 R5 status sweep", v, {st, 11'b0});
                chk("R9 irq sweep", {15'b0, irq_out}, {15'b0, |st});
                chk("R10 wake sweep", {15'b0, wake_req}, {15'b0, |(st & 5'b10110)});
            end
        end

        // R6 R7 sticky source on bit 15, active high
        wr(2'd0, 16'hF800);
        wr(2'd2, 16'h8000);
        src_raw = 5'h00; tick(2);
        wr(2'd1, 16'h8000);
        src_raw = 5'h10; tick(2);
        src_raw = 5'h00; tick(3);
        rd(2'd3, v); chk("R6 latch holds", v, 16'h8000);
        chk("R10 wake from latch", {15'b0, wake_req}, 16'h1);
        rd(2'd0, v); rd(2'd3, v); chk("R7 read does not clear", v, 16'h8000);
        wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R7 write one no effect", v, 16'h8000);
        wr(2'd3, 16'h7FFF); rd(2'd3, v); chk("R7 write zero clears", v, 16'h0000);
        chk("R9 irq after clear", {15'b0, irq_out}, 16'h0);

        // R5 non-sticky neighbour unaffected by sticky setting
        src_raw = 5'h08; tick(2);
        src_raw = 5'h00; tick(2);
        rd(2'd3, v); chk("R5 pass-through drops", v, 16'h0000);

        // R8 set wins over clear in the same cycle
        src_raw = 5'h10; tick(1);
        src_raw = 5'h00; tick(1);
        wr(2'd3, 16'h0000);
        rd(2'd3, v); chk("R8 set beats clear", v, 16'h8000);
        wr(2'd3, 16'h0000);
        rd(2'd3, v); chk("R8 later clear", v, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule